// File: doc/BRIEF.md
# Cache Line Scrub Sequencer

This block decides which line of a set-associative cache array gets scrubbed next, and when. Each scrub step is one request/acknowledge handshake. The request names a line by set index and way. The array reads that line, checks it, corrects it and writes it back, then acknowledges. The sequencer generates no check bits and checks none. It only passes on the flag the array returns when it corrected an error.

Software selects the work through two registers.

- **Control register.** It holds a target line, a pending bit and an enable bit. The pending bit asks for a single scrub of the target line. The enable bit starts an endless walk over every line of the array.
- **Delay register.** It sets how many idle cycles separate consecutive steps of the walk.

A one-shot request always goes ahead of the walk. Afterwards the walk resumes at the line where it stopped. No step is launched in a cycle in which the array reports that normal traffic occupies it.

Top module: `scrub_seq`

## Requirements
- R1: After reset `scr_req` and `corr_evt` are low, both registers read as zero, and the first walk step targets index 0, way 0.
- R2: The control register is at `cfg_addr`=0. The target index is in bits 15:0 (low IDX_W bits used), the target way in bits 23:16 (low WAY_W bits used), pending in bit 30 and enable in bit 31. The delay register is at `cfg_addr`=1 in bits DLY_W-1:0. Unused bits read 0. Writing 0 to the pending bit has no effect on it.
- R3: Writing 1 to the pending bit launches one step on the target line. Pending reads 1 until the clock edge that samples that step's acknowledge, and reads 0 from then on.
- R4: With enable set, the walk visits lines with the way advancing fastest and the index advancing next. After the last index and last way it wraps to index 0, way 0.
- R5: Take a walk step acknowledged at edge e, with delay value D. If the array stays free and no one-shot is pending, the next walk step's `scr_req` rises at edge e+D+1. With D=0 this leaves exactly one idle cycle between steps.
- R6: Once raised, `scr_req` stays high with a stable `scr_idx`/`scr_way` until an edge samples `scr_ack` high. It is low after that edge.
- R7: `scr_req` rises only at an edge where `arr_busy` is low.
- R8: A pending one-shot is served before the next walk step, even during the delay gap. The walk then continues from the line it would have scrubbed next.
- R9: Clearing enable lets the step in flight finish. No further walk step is launched while enable stays clear.
- R10: `corr_evt` is high for one cycle after each edge at which `scr_req`, `scr_ack` and `scr_corr` are all high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 control, 1 delay |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register (combinational) |
| arr_busy | input | 1 | Array occupied by normal traffic |
| scr_req | output | 1 | Scrub step request |
| scr_idx | output | IDX_W | Set index of the requested line |
| scr_way | output | WAY_W | Way of the requested line |
| scr_ack | input | 1 | Array finished the step |
| scr_corr | input | 1 | Array corrected an error in this step (valid with `scr_ack`) |
| corr_evt | output | 1 | Corrected-error pulse |

## Verification
The hardest case to reach is a one-shot request that is written while the walk is counting down its delay gap. Reaching it requires the register write to land within the few cycles between an acknowledge and the next walk launch, while the array happens to be free. The stimulus runs the walk with a long delay and random array latency and busy bursts. Between steps it fires one-shot writes with random targets at random cycles, and some of them land inside the gap. A directed pass also writes a one-shot just after a walk acknowledge. In both cases the bench model predicts whether the next rising request is the one-shot line or the next walk line, and checks that the walk resumes at the right place.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  localparam int REG_W        = 32;
  localparam int CTRL_WAY_LSB = 16;
  localparam int CTRL_PEND    = 30;
  localparam int CTRL_EN      = 31;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_STEP = 1'b1
  } step_state_t;

  // Delay gap countdown: load on a finished walk step, else count to zero.
  function automatic logic [15:0] gap_next(input logic [15:0] cur,
                                           input logic [15:0] dly,
                                           input logic        load);
    if (load)            return dly;
    else if (cur != '0)  return cur - 16'd1;
    else                 return cur;
  endfunction
endpackage

// File: rtl/scrub_regs.sv
module scrub_regs
  import scrub_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int WAY_W = 2,
  parameter int DLY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              oneshot_done,
  output logic [REG_W-1:0]  rdata,
  output logic [IDX_W-1:0]  tgt_idx,
  output logic [WAY_W-1:0]  tgt_way,
  output logic              pend,
  output logic              en,
  output logic [DLY_W-1:0]  delay
);
  logic wr_ctrl, wr_dly, set_pend;

  assign wr_ctrl  = we && (addr == 1'b0);
  assign wr_dly   = we && (addr == 1'b1);
  assign set_pend = wr_ctrl && wdata[CTRL_PEND];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_idx <= '0;
      tgt_way <= '0;
      pend    <= 1'b0;
      en      <= 1'b0;
      delay   <= '0;
    end else begin
      if (wr_ctrl) begin
        tgt_idx <= wdata[IDX_W-1:0];
        tgt_way <= wdata[CTRL_WAY_LSB +: WAY_W];
        en      <= wdata[CTRL_EN];
      end
      if (wr_dly) delay <= wdata[DLY_W-1:0];
      pend <= (pend && !oneshot_done) || set_pend;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == 1'b0) begin
      rdata[IDX_W-1:0]                = tgt_idx;
      rdata[CTRL_WAY_LSB +: WAY_W]    = tgt_way;
      rdata[CTRL_PEND]                = pend;
      rdata[CTRL_EN]                  = en;
    end else begin
      rdata[DLY_W-1:0]                = delay;
    end
  end
endmodule

// File: rtl/scrub_walk.sv
module scrub_walk #(
  parameter int IDX_W = 6,
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [IDX_W-1:0] cur_idx,
  output logic [WAY_W-1:0] cur_way
);
  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

  // Way is the fast digit, index the slow one; both wrap to zero.
  function automatic logic [IDX_W+WAY_W-1:0] next_line(input logic [IDX_W-1:0] idx,
                                                       input logic [WAY_W-1:0] way);
    if (way == LAST_WAY) return {idx + 1'b1, {WAY_W{1'b0}}};
    else                 return {idx, way + 1'b1};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_idx <= '0;
      cur_way <= '0;
    end else if (advance) begin
      {cur_idx, cur_way} <= next_line(cur_idx, cur_way);
    end
  end
endmodule

// File: rtl/scrub_fsm.sv
module scrub_fsm
  import scrub_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend,
  input  logic             en,
  input  logic [DLY_W-1:0] delay,
  input  logic             busy,
  input  logic             ack,
  output logic             req,
  output logic             kind_one,
  output logic             launch_one,
  output logic             launch_cont,
  output logic             done_one,
  output logic             done_cont
);
  step_state_t      st;
  logic [DLY_W-1:0] gap;
  logic             step_end;
  logic [15:0]      gap_w;

  assign launch_one  = (st == ST_IDLE) && !busy && pend;
  assign launch_cont = (st == ST_IDLE) && !busy && !pend && en && (gap == '0);
  assign step_end    = (st == ST_STEP) && ack;
  assign done_one    = step_end && kind_one;
  assign done_cont   = step_end && !kind_one;
  assign req         = (st == ST_STEP);
  assign gap_w       = gap_next(16'(gap), 16'(delay), done_cont);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      kind_one <= 1'b0;
      gap      <= '0;
    end else begin
      gap <= gap_w[DLY_W-1:0];
      if (launch_one || launch_cont) begin
        st       <= ST_STEP;
        kind_one <= launch_one;
      end else if (step_end) begin
        st <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/scrub_seq.sv
module scrub_seq
  import scrub_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int WAYS  = 4,
  parameter int DLY_W = 8,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             arr_busy,
  output logic             scr_req,
  output logic [IDX_W-1:0] scr_idx,
  output logic [WAY_W-1:0] scr_way,
  input  logic             scr_ack,
  input  logic             scr_corr,
  output logic             corr_evt
);
  logic [IDX_W-1:0] tgt_idx, walk_idx;
  logic [WAY_W-1:0] tgt_way, walk_way;
  logic             pend, en, kind_one;
  logic             launch_one, launch_cont, done_one, done_cont;
  logic [DLY_W-1:0] delay;

  scrub_regs #(.IDX_W(IDX_W), .WAY_W(WAY_W), .DLY_W(DLY_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .oneshot_done(done_one), .rdata(cfg_rdata), .tgt_idx(tgt_idx),
    .tgt_way(tgt_way), .pend(pend), .en(en), .delay(delay)
  );

  scrub_walk #(.IDX_W(IDX_W), .WAYS(WAYS), .WAY_W(WAY_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .advance(done_cont),
    .cur_idx(walk_idx), .cur_way(walk_way)
  );

  scrub_fsm #(.DLY_W(DLY_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pend(pend), .en(en), .delay(delay),
    .busy(arr_busy), .ack(scr_ack), .req(scr_req), .kind_one(kind_one),
    .launch_one(launch_one), .launch_cont(launch_cont),
    .done_one(done_one), .done_cont(done_cont)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scr_idx  <= '0;
      scr_way  <= '0;
      corr_evt <= 1'b0;
    end else begin
      if (launch_one) begin
        scr_idx <= tgt_idx;
        scr_way <= tgt_way;
      end else if (launch_cont) begin
        scr_idx <= walk_idx;
        scr_way <= walk_way;
      end
      corr_evt <= scr_req && scr_ack && scr_corr;
    end
  end
endmodule

// File: rtl/scrub_seq_chk.sv
module scrub_seq_chk #(
  parameter int IDX_W = 6,
  parameter int WAY_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             cfg_addr,
  input logic [31:0]      cfg_wdata,
  input logic             arr_busy,
  input logic             scr_req,
  input logic [IDX_W-1:0] scr_idx,
  input logic [WAY_W-1:0] scr_way,
  input logic             scr_ack,
  input logic             corr_evt,
  input logic             pend,
  input logic             en,
  input logic             kind_one,
  input logic             done_one,
  input logic             done_cont,
  input logic [IDX_W-1:0] walk_idx,
  input logic [WAY_W-1:0] walk_way
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    scr_req && !scr_ack |=> scr_req && $stable(scr_idx) && $stable(scr_way)); // R6
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    scr_req && scr_ack |=> !scr_req); // R6
  AST_LAUNCH_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scr_req) |-> $past(!arr_busy)); // R7
  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done_one && !(cfg_we && !cfg_addr && cfg_wdata[30]) |=> !pend); // R3
  AST_ONESHOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !scr_req && !arr_busy |=> scr_req && kind_one); // R8
  AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_cont |=> $stable(walk_idx) && $stable(walk_way)); // R8
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !scr_req && !pend && !en |=> !scr_req); // R9
  AST_CORR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    corr_evt |-> $past(scr_req && scr_ack)); // R10
endmodule

bind scrub_seq scrub_seq_chk #(.IDX_W(IDX_W), .WAY_W(WAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .arr_busy(arr_busy), .scr_req(scr_req),
  .scr_idx(scr_idx), .scr_way(scr_way), .scr_ack(scr_ack), .corr_evt(corr_evt),
  .pend(pend), .en(en), .kind_one(kind_one), .done_one(done_one),
  .done_cont(done_cont), .walk_idx(walk_idx), .walk_way(walk_way)
);

// File: tb/scrub_seq_test.sv
module scrub_seq_test;
  localparam int IDX_W = 6;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;
  localparam int DLY_W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cfg_we, cfg_addr, arr_busy, scr_ack, scr_corr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic scr_req, corr_evt;
  logic [IDX_W-1:0] scr_idx;
  logic [WAY_W-1:0] scr_way;

  scrub_seq #(.IDX_W(IDX_W), .WAYS(WAYS), .DLY_W(DLY_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .arr_busy(arr_busy),
    .scr_req(scr_req), .scr_idx(scr_idx), .scr_way(scr_way),
    .scr_ack(scr_ack), .scr_corr(scr_corr), .corr_evt(corr_evt)
  );

  int vecs = 0, bad = 0, cyc = 0;
  // bench model state
  bit pend_m = 0, en_m = 0, cur_one = 0, prev_req = 0, clean = 0;
  int o_idx = 0, o_way = 0, w_idx = 0, w_way = 0, dly_m = 0, last_done = 0;
  int lat = 0, busy_pct = 0, p_idx = 0, p_way = 0;
  int walk_steps = 0;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", r, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] ctrl_word(input bit en, input bit pd, input int idx, input int way);
    return {en, pd, 6'd0, 8'(way), 16'(idx)};
  endfunction

  task automatic step_walk_model();
    if (w_way == WAYS - 1) begin
      w_way = 0;
      w_idx = (w_idx + 1) % (1 << IDX_W);
    end else w_way = w_way + 1;
  endtask

  task automatic tick();
    bit was_req = prev_req, a = scr_ack, c = scr_corr, b = arr_busy;
    bit wr = cfg_we && !cfg_addr, wd_wr = cfg_we && cfg_addr;
    logic [31:0] wd = cfg_wdata;
    @(posedge clk);
    @(negedge clk);
    cyc++;
    // step completion
    if (was_req && a) begin
      chk(!scr_req, "R6", scr_req, 0);
      if (cur_one) begin
        if (!(wr && wd[30])) pend_m = 0;
        chk(cfg_rdata[30] == pend_m, "R3", cfg_rdata[30], pend_m);
      end else begin
        step_walk_model();
        walk_steps++;
        last_done = cyc;
        clean = 1;
      end
    end else if (was_req) begin
      chk(scr_req && scr_idx == p_idx && scr_way == p_way, "R6", scr_idx, p_idx);
    end
    chk(corr_evt == (was_req && a && c), "R10", corr_evt, was_req && a && c);
    if (!was_req && b) clean = 0;
    // new step launched
    if (!was_req && scr_req) begin
      chk(!b, "R7", b, 0);
      if (pend_m) begin
        cur_one = 1;
        chk(scr_idx == o_idx && scr_way == o_way, "R8", {scr_idx, scr_way}, o_idx * 4 + o_way);
      end else begin
        cur_one = 0;
        chk(en_m, "R9", 1, en_m);
        chk(scr_idx == w_idx && scr_way == w_way, "R4", {scr_idx, scr_way}, w_idx * 4 + w_way);
        if (clean) chk(cyc - last_done == dly_m + 1, "R5", cyc - last_done, dly_m + 1);
      end
      clean = 0;
      lat = $urandom % 3;
    end
    if (pend_m) clean = 0;
    // register side effects become visible to the next launch decision
    if (wr) begin
      o_idx = wd[IDX_W-1:0];
      o_way = wd[16 +: WAY_W];
      en_m  = wd[31];
      if (wd[30]) pend_m = 1;
    end
    if (wd_wr) begin
      dly_m = wd[DLY_W-1:0];
      clean = 0;
    end
    prev_req = scr_req;
    p_idx = scr_idx;
    p_way = scr_way;
    // array model drives ack for the next edge
    scr_ack = 1'b0;
    scr_corr = 1'b0;
    if (scr_req) begin
      if (lat == 0) begin
        scr_ack = 1'b1;
        scr_corr = ($urandom % 4) == 0;
      end else lat--;
    end
    arr_busy = (($urandom % 100) < busy_pct);
  endtask

  task automatic wr_reg(input bit a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0; cfg_addr = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #3000000;
    bad++;
    $display("FAIL watchdog: actual %0d expected 0 (run did not end)", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5c2b));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 1'b0; cfg_wdata = '0;
    arr_busy = 1'b0; scr_ack = 1'b0; scr_corr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    run(2);
    // R1: reset state
    chk(!scr_req, "R1", scr_req, 0);
    chk(!corr_evt, "R1", corr_evt, 0);
    chk(cfg_rdata == 0, "R1", cfg_rdata, 0);
    cfg_addr = 1'b1; #1;
    chk(cfg_rdata == 0, "R1", cfg_rdata, 0);
    cfg_addr = 1'b0;

    // R2: field readback, pending write-0 ignored (array busy holds the step off)
    busy_pct = 100; arr_busy = 1'b1;
    wr_reg(1'b1, 32'h0000_0005);
    cfg_addr = 1'b1; #1;
    chk(cfg_rdata == 32'h5, "R2", cfg_rdata, 5);
    cfg_addr = 1'b0;
    wr_reg(1'b0, ctrl_word(0, 1, 45, 3));
    run(3);
    chk(cfg_rdata == ctrl_word(0, 1, 45, 3), "R2", cfg_rdata, ctrl_word(0, 1, 45, 3));
    wr_reg(1'b0, ctrl_word(0, 0, 9, 1));
    chk(cfg_rdata[30] == 1'b1, "R2", cfg_rdata[30], 1);
    chk(!scr_req, "R7", scr_req, 0);
    busy_pct = 0;
    run(10);
    chk(!cfg_rdata[30], "R3", cfg_rdata[30], 0);

    // R3: random one-shots, walk off
    for (int k = 0; k < 12; k++) begin
      busy_pct = (k % 3) * 20;
      wr_reg(1'b0, ctrl_word(0, 1, $urandom % 64, $urandom % 4));
      run(12);
      chk(!scr_req && !cfg_rdata[30], "R3", cfg_rdata[30], 0);
    end

    // R4/R5: walk with delay 0, full pass plus wrap
    busy_pct = 0;
    wr_reg(1'b1, 32'h0);
    wr_reg(1'b0, ctrl_word(1, 0, 0, 0));
    run(1200);
    chk(walk_steps > 256, "R4", walk_steps, 257);

    // R5/R7/R8: long delay, busy bursts, one-shots landing in the gap
    wr_reg(1'b1, 32'd7);
    for (int k = 0; k < 300; k++) begin
      busy_pct = (k % 50 < 25) ? 0 : 30;
      if (!pend_m && !(scr_req && cur_one) && ($urandom % 6) == 0)
        wr_reg(1'b0, ctrl_word(1, 1, $urandom % 64, $urandom % 4));
      run($urandom % 9);
    end
    // directed: one-shot right after a walk acknowledge
    busy_pct = 0;
    run(20);
    while (!(scr_req && !cur_one && scr_ack)) tick();
    tick();
    wr_reg(1'b0, ctrl_word(1, 1, 63, 3));
    run(40);
    chk(!pend_m, "R8", pend_m, 0);

    // R9: clear enable while a walk step is in flight, then resume
    while (!(scr_req && !cur_one)) tick();
    wr_reg(1'b0, ctrl_word(0, 0, 0, 0));
    run(60);
    chk(!scr_req, "R9", scr_req, 0);
    wr_reg(1'b1, 32'd0);
    wr_reg(1'b0, ctrl_word(1, 0, 0, 0));
    run(100);
    wr_reg(1'b0, ctrl_word(0, 0, 0, 0));
    run(20);
    chk(!scr_req, "R9", scr_req, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule